// File: doc/BRIEF.md
# Serial Audio Frame Master, Right-Justified With One-Bit MSB Delay

This block is the clock master of a stereo serial audio link. It divides a fast master clock down to a bit clock. It also generates a left/right clock that marks which channel is on the line, and a word strobe that is high for one bit period. Each 64-bit frame carries two 32-bit fields, left first. The 16-bit sample of each field is placed at the right of the field but delayed by one bit. The MSB is driven in the 18th bit period of the field. The LSB spills into the first bit period of the following field.

Once per frame, during the last bit period of the right field, the block raises a one-master-clock request. The source then presents the next left and right samples. Both words are captured together at the frame boundary and held for the whole frame. Receivers sample serial data on the rising edge of the bit clock. Every output changes on the falling edge.

Top module: `audio_rj_master`

## Requirements
- R1: `bclk` is `mclk` divided by `DIV` (default 4), high for `DIV/2` master-clock cycles and low for `DIV/2` cycles. Its falling edge is the transmit edge and its rising edge is the sampling edge.
- R2: A frame is 64 bit periods, numbered 0 to 63 starting at a falling edge of `bclk`. `lrclk` is 1 in periods 0–31 (left field) and 0 in periods 32–63 (right field).
- R3: `wstrb` is 1 for exactly one bit period per field: field position 16, which is the 17th period of the field.
- R4: At field positions 17 through 31, `sdata` carries the field's word MSB first: position p carries bit 32−p. Bit 0 of that word is driven at position 0 of the following field, so the right word's bit 0 appears in period 0 of the next frame.
- R5: `sdata` is 0 at field positions 1 through 16.
- R6: `lrclk`, `wstrb` and `sdata` change only at a falling edge of `bclk`.
- R7: `req` is high for exactly one `mclk` cycle per frame: the first cycle of period 63, when `lrclk` is 0. `left_in` and `right_in` are captured at the end of period 63. Changing them at any other time has no effect on `sdata` for the frame being sent.
- R8: While `rst_n` is low, `bclk`, `wstrb`, `sdata` and `req` are 0 and `lrclk` is 1. After release the first frame begins at period 0 of the left field and sends all-zero words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released synchronously inside the block |
| left_in | input | 16 | Next left sample, captured at the frame boundary |
| right_in | input | 16 | Next right sample, captured at the frame boundary |
| bclk | output | 1 | Bit clock, `mclk`/`DIV` |
| lrclk | output | 1 | Channel select: 1 = left field, 0 = right field |
| wstrb | output | 1 | Word strobe, high in the 17th bit period of each field |
| sdata | output | 1 | Serial data, MSB first |
| req | output | 1 | One-cycle request for the next sample pair |

## Verification
Every serial output is registered on the `mclk` edge that drops `bclk`. A value set for bit period k is therefore present half a bit period before the rising edge of period k. The bench polls at falling `mclk` edges, finds each rising edge of `bclk`, and samples there. That is the receiver's own sampling point, and it lies a full half period after the transmit edge. `req` is seen at the first falling `mclk` edge of period 63. The bench writes new samples at that point, three `mclk` cycles before the capture edge. Its frame checks stop at period 62, so they never overlap the next request, and the spilled LSB is checked at period 0 of the next frame. After reset, two synchronizer cycles pass before the divider runs. This is why the first rising edge is found by polling rather than at a fixed cycle.

// File: rtl/audio_rj_master.sv
module audio_rj_master #(
  parameter int DIV   = 4,
  parameter int WIDTH = 16
) (
  input  logic             mclk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] left_in,
  input  logic [WIDTH-1:0] right_in,
  output logic             bclk,
  output logic             lrclk,
  output logic             wstrb,
  output logic             sdata,
  output logic             req
);
  localparam int FIELD = 32;
  localparam int CW    = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int IW    = $clog2(WIDTH);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] MID  = CW'(DIV / 2 - 1);
  localparam logic [4:0] STB_POS = 5'(FIELD - WIDTH);
  localparam logic [4:0] MSB_POS = 5'(FIELD - WIDTH + 1);

  logic [1:0]       rsync;
  logic [CW-1:0]    div_cnt;
  logic [5:0]       bit_cnt;
  logic [WIDTH-1:0] l_sh, r_sh;

  wire run = rsync[1];
  wire tx  = run && (div_cnt == LAST);

  wire [5:0]       nxt   = bit_cnt + 6'd1;
  wire [4:0]       pos_n = nxt[4:0];
  wire [WIDTH-1:0] cur_w = nxt[5] ? r_sh : l_sh;
  wire [WIDTH-1:0] prv_w = nxt[5] ? l_sh : r_sh;
  wire [5:0]       idx   = 6'(FIELD) - {1'b0, pos_n};

  logic bit_n;
  always_comb begin
    if (pos_n == 5'd0)
      bit_n = prv_w[0];
    else if (pos_n >= MSB_POS)
      bit_n = cur_w[idx[IW-1:0]];
    else
      bit_n = 1'b0;
  end

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      bclk    <= 1'b0;
    end else if (run) begin
      div_cnt <= tx ? '0 : div_cnt + 1'b1;
      if (div_cnt == MID) bclk <= 1'b1;
      else if (tx)        bclk <= 1'b0;
    end
  end

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      lrclk   <= 1'b1;
      wstrb   <= 1'b0;
      sdata   <= 1'b0;
      req     <= 1'b0;
      l_sh    <= '0;
      r_sh    <= '0;
    end else begin
      req <= tx && (nxt == 6'd63);
      if (tx) begin
        bit_cnt <= nxt;
        lrclk   <= ~nxt[5];
        wstrb   <= (pos_n == STB_POS);
        sdata   <= bit_n;
        if (nxt == 6'd0) begin
          l_sh <= left_in;
          r_sh <= right_in;
        end
      end
    end
  end
endmodule

module audio_rj_master_chk #(
  parameter int DIV   = 4,
  parameter int WIDTH = 16
) (
  input logic mclk,
  input logic rst_n,
  input logic bclk,
  input logic lrclk,
  input logic wstrb,
  input logic sdata,
  input logic req
);
  localparam logic [4:0] STB_POS = 5'(32 - WIDTH);
  logic       lr_q, b_q;
  logic [4:0] fld;

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      lr_q <= 1'b1;
      b_q  <= 1'b0;
      fld  <= '0;
    end else begin
      lr_q <= lrclk;
      b_q  <= bclk;
      if (lrclk != lr_q)      fld <= '0;
      else if (b_q && !bclk)  fld <= fld + 5'd1;
    end
  end

  a_r6_lr_on_fall: assert property (@(posedge mclk) disable iff (!rst_n)
    !$stable(lrclk) |-> $fell(bclk));
  a_r6_strobe_on_fall: assert property (@(posedge mclk) disable iff (!rst_n)
    !$stable(wstrb) |-> $fell(bclk));
  a_r6_data_on_fall: assert property (@(posedge mclk) disable iff (!rst_n)
    !$stable(sdata) |-> $fell(bclk));
  a_r3_strobe_pos: assert property (@(posedge mclk) disable iff (!rst_n)
    (wstrb && bclk) |-> (fld == STB_POS));
  a_r7_req_single: assert property (@(posedge mclk) disable iff (!rst_n)
    req |=> !req);
  a_r7_req_right: assert property (@(posedge mclk) disable iff (!rst_n)
    req |-> !lrclk);
endmodule

bind audio_rj_master audio_rj_master_chk #(.DIV(DIV), .WIDTH(WIDTH)) i_chk (
  .mclk(mclk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk),
  .wstrb(wstrb), .sdata(sdata), .req(req));

// File: tb/test_audio_rj_master.sv
`timescale 1ns/1ps
module test_audio_rj_master;
  localparam int DIV = 4;
  localparam int W   = 16;

  logic         mclk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] left_in = '0, right_in = '0;
  logic         bclk, lrclk, wstrb, sdata, req;
  int           checks = 0, errors = 0;
  int           gap, hi;
  logic [W-1:0] last_r = '0;

  always #2.5 mclk = ~mclk;

  audio_rj_master #(.DIV(DIV), .WIDTH(W)) i_audio_rj_master (
    .mclk(mclk), .rst_n(rst_n), .left_in(left_in), .right_in(right_in),
    .bclk(bclk), .lrclk(lrclk), .wstrb(wstrb), .sdata(sdata), .req(req));

  task automatic chk(input logic ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", rq, act, exp, $time);
    end
  endtask

  task automatic next_rise();
    logic p;
    p = bclk; gap = 0; hi = 0;
    forever begin
      @(negedge mclk);
      gap++;
      if (bclk) hi++;
      if (bclk && !p) break;
      p = bclk;
    end
  endtask

  function automatic logic exp_bit(int k, logic [W-1:0] l, logic [W-1:0] r, logic [W-1:0] pr);
    int pos;
    logic [W-1:0] cur, prv;
    pos = k % 32;
    cur = (k < 32) ? l : r;
    prv = (k < 32) ? pr : l;
    if (pos == 0) return prv[0];
    if (pos >= 17) return cur[32 - pos];
    return 1'b0;
  endfunction

  task automatic check_period(int k, logic [W-1:0] l, logic [W-1:0] r, logic [W-1:0] pr);
    int pos;
    logic e;
    pos = k % 32;
    e = exp_bit(k, l, r, pr);
    chk(lrclk == (k < 32), "R2 lrclk", lrclk, k < 32);
    chk(wstrb == (pos == 16), "R3 wstrb position", wstrb, pos == 16);
    if (pos >= 1 && pos <= 16)
      chk(sdata == 1'b0, "R5 idle data", sdata, 0);
    else
      chk(sdata == e, "R4 data bit", sdata, e);
  endtask

  task automatic t_reset();
    @(negedge mclk);
    chk(!bclk && lrclk && !wstrb && !sdata && !req, "R8 reset outputs",
        {bclk, lrclk, wstrb, sdata, req}, 5'b01000);
    rst_n = 1'b1;
    for (int k = 0; k < 63; k++) begin
      next_rise();
      if (k > 0) begin
        chk(gap == DIV, "R1 bclk period", gap, DIV);
        chk(hi == DIV / 2, "R1 bclk high time", hi, DIV / 2);
      end
      chk(sdata == 1'b0, "R8 first frame zero", sdata, 0);
      check_period(k, '0, '0, '0);
    end
    last_r = '0;
  endtask

  task automatic run_frame(input logic [W-1:0] l, input logic [W-1:0] r, input bit junk);
    forever begin
      @(negedge mclk);
      if (req) break;
    end
    chk(lrclk == 1'b0, "R7 req in right field", lrclk, 0);
    left_in = l; right_in = r;
    @(negedge mclk);
    chk(req == 1'b0, "R7 req one cycle", req, 0);
    next_rise();
    for (int k = 0; k < 63; k++) begin
      next_rise();
      check_period(k, l, r, last_r);
      if (junk && k == 3) begin
        left_in = ~l; right_in = ~r;
      end
    end
    last_r = r;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #12;
    t_reset();
    run_frame(16'h8001, 16'h7FFE, 1'b0);
    run_frame(16'hA5C3, 16'h3C5A, 1'b0);
    run_frame(16'hFFFF, 16'h0000, 1'b0);
    run_frame(16'h1234, 16'hFEDC, 1'b1);
    run_frame(16'h0001, 16'h8000, 1'b0);
    run_frame(16'h0000, 16'h0000, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule